// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the combinational datapath of a small accumulator-based processor core. In a single evaluation it takes the accumulator, a second operand, the B register and the current status byte. It returns the new accumulator, the new B register and the new status byte for one of sixteen operations. Those operations cover binary add and subtract, decimal correction, multiply and divide, rotates, nibble swap and bitwise logic.

The surrounding core is responsible for decoding, addressing and register writeback. It presents the operands and a 4-bit operation code, then latches the outputs. Flags that an operation does not touch pass through from the incoming status byte unchanged. The core can therefore always write back the whole status byte.

Status byte layout: CY at bit 7, AC at bit 6, OV at bit 2, P at bit 0. Bits 5, 4, 3 and 1 are unused by this block.

Top module: `acc_alu`

## Requirements
- R1: For op 0 (ADD) and op 1 (ADDC), A becomes A + operand, plus CY for ADDC. CY is the carry out of bit 7, AC is the carry out of bit 3, and OV is set when two operands of equal sign give a result of the other sign.
- R2: For op 2 (SUBB), A becomes A - operand - CY, computed modulo 256. CY=1 when the true difference is negative. AC=1 when the low nibble needed a borrow. OV is set when the signed difference lies outside -128..127.
- R3: The status byte places CY at bit 7, AC at bit 6, OV at bit 2 and P at bit 0. After every op, P is 1 exactly when the new A holds an odd number of ones.
- R4: For op 3 (DA), 06h is added when the low nibble exceeds 9 or AC=1. 60h is then added when the high nibble exceeds 9, when CY=1, or when the first step carried. CY is set by any carry out of these additions and is never cleared.
- R5: For op 4 (MUL), the 16-bit product A*B is split so that the high byte goes to B and the low byte to A. OV=1 when the product exceeds FFh, and CY=0.
- R6: For op 5 (DIV), A gets the quotient A/B and B gets the remainder, with OV=0 and CY=0. When B=0, OV=1, CY=0, and A and B are returned unchanged.
- R7: Op 6 rotates A left and op 8 rotates A right, both circularly. Op 7 rotates left and op 9 rotates right through a 9-bit loop that includes CY.
- R8: Op 10 (SWAP) exchanges bits 7..4 with bits 3..0 of A.
- R9: Ops 11, 12 and 13 give A AND, OR and XOR the operand. Op 14 complements A, and op 15 leaves A unchanged.
- R10: Flags an op does not define keep their incoming values, and status bits 5, 4, 3 and 1 always pass through. B is unchanged by every op except MUL and DIV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand |
| breg_i | input | 8 | Current B register |
| psw_i | input | 8 | Current status byte |
| acc_o | output | 8 | New accumulator |
| breg_o | output | 8 | New B register |
| psw_o | output | 8 | New status byte |

## Verification
The hardest case to reach is the decimal adjust where the sticky carry and the second-stage correction interact. The incoming status byte must already hold a carry and an auxiliary carry that an earlier addition left behind, while the accumulator holds a value that alone would need no high correction. The bench reproduces this by running the addition 99h+99h, then feeding its output accumulator and status byte back as the inputs of the adjust step. It also drives an adjust where the first-stage correction alone produces the high-nibble overflow. A sweep of add and subtract cases is checked against an integer model that the bench computes on its own.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int W      = 8;
  localparam int NIB    = W / 2;
  localparam int OP_W   = 4;
  localparam int CY_BIT = 7;
  localparam int AC_BIT = 6;
  localparam int OV_BIT = 2;
  localparam int P_BIT  = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUBB = 4'd2,  OP_DA   = 4'd3,
    OP_MUL  = 4'd4,  OP_DIV  = 4'd5,  OP_RL   = 4'd6,  OP_RLC  = 4'd7,
    OP_RR   = 4'd8,  OP_RRC  = 4'd9,  OP_SWAP = 4'd10, OP_AND  = 4'd11,
    OP_OR   = 4'd12, OP_XOR  = 4'd13, OP_CPL  = 4'd14, OP_PASS = 4'd15
  } alu_op_e;

  function automatic logic odd_parity(input logic [W-1:0] v);
    return ^v;
  endfunction

  function automatic logic signed_ovf(input logic a_msb, input logic b_msb,
                                      input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = W,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o
);
  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [DATA_W:0]   full;
  logic [HALF_W:0]   low;

  // Subtraction adds the inverted subtrahend; the inverted borrow acts as carry-in.
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = sub_i ? ~cin_i : cin_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
  assign low   = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, c_eff};

  assign sum_o = full[DATA_W-1:0];
  assign cy_o  = full[DATA_W] ^ sub_i;
  assign ac_o  = low[HALF_W] ^ sub_i;
  assign ov_o  = signed_ovf(a_i[DATA_W-1], b_eff[DATA_W-1], full[DATA_W-1]);
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = W,
  localparam int HALF_W = DATA_W / 2,
  localparam logic [DATA_W:0] LO_FIX = (DATA_W+1)'(6),
  localparam logic [DATA_W:0] HI_FIX = (DATA_W+1)'(6) << HALF_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              cy_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              lo_step_o,
  output logic              hi_step_o
);
  logic [DATA_W:0] stage1;
  logic [DATA_W:0] stage2;

  assign lo_step_o = (a_i[HALF_W-1:0] > HALF_W'(9)) || ac_i;
  assign stage1    = {1'b0, a_i} + (lo_step_o ? LO_FIX : '0);
  assign hi_step_o = (stage1[DATA_W-1:HALF_W] > HALF_W'(9)) || cy_i || stage1[DATA_W];
  assign stage2    = {1'b0, stage1[DATA_W-1:0]} + (hi_step_o ? HI_FIX : '0);
  assign res_o     = stage2[DATA_W-1:0];
  assign cy_o      = cy_i | stage1[DATA_W] | stage2[DATA_W];
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] prod_lo_o,
  output logic [DATA_W-1:0] prod_hi_o,
  output logic              prod_wide_o,
  output logic [DATA_W-1:0] quot_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              div_zero_o
);
  logic [2*DATA_W-1:0] prod;

  assign prod        = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
  assign prod_lo_o   = prod[DATA_W-1:0];
  assign prod_hi_o   = prod[2*DATA_W-1:DATA_W];
  assign prod_wide_o = |prod_hi_o;
  assign div_zero_o  = (b_i == '0);

  // On a zero divisor the operands are returned untouched.
  always_comb begin
    if (div_zero_o) begin
      quot_o = a_i;
      rem_o  = b_i;
    end else begin
      quot_o = a_i / b_i;
      rem_o  = a_i % b_i;
    end
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = W,
  localparam int HALF_W = DATA_W / 2
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    unique case (op_i)
      OP_RL:   res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
      OP_RR:   res_o = {a_i[0], a_i[DATA_W-1:1]};
      OP_RLC:  {cy_o, res_o} = {a_i, cy_i};
      OP_RRC:  {res_o, cy_o} = {cy_i, a_i};
      OP_SWAP: res_o = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]};
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_CPL:  res_o = ~a_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = W
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] breg_i,
  input  logic [7:0]        psw_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] breg_o,
  output logic [7:0]        psw_o
);
  alu_op_e op;
  logic    cy_in, ac_in;
  assign op    = alu_op_e'(op_i);
  assign cy_in = psw_i[CY_BIT];
  assign ac_in = psw_i[AC_BIT];

  // Named internal events, visible to the checker.
  logic [DATA_W-1:0] as_sum, da_res, bit_res, prod_lo, prod_hi, quot, rem;
  logic as_cy, as_ac, as_ov, da_cy, da_lo_step, da_hi_step, bit_cy;
  logic prod_wide, div_zero, as_sub, as_cin;

  assign as_sub = (op == OP_SUBB);
  assign as_cin = (op == OP_ADD) ? 1'b0 : cy_in;

  acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(acc_i), .b_i(opnd_i), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov));

  acc_alu_decadj #(.DATA_W(DATA_W)) u_decadj (
    .a_i(acc_i), .cy_i(cy_in), .ac_i(ac_in), .res_o(da_res), .cy_o(da_cy),
    .lo_step_o(da_lo_step), .hi_step_o(da_hi_step));

  acc_alu_muldiv #(.DATA_W(DATA_W)) u_muldiv (
    .a_i(acc_i), .b_i(breg_i), .prod_lo_o(prod_lo), .prod_hi_o(prod_hi),
    .prod_wide_o(prod_wide), .quot_o(quot), .rem_o(rem), .div_zero_o(div_zero));

  acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(cy_in),
    .res_o(bit_res), .cy_o(bit_cy));

  always_comb begin
    acc_o  = bit_res;
    breg_o = breg_i;
    psw_o  = psw_i;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        acc_o          = as_sum;
        psw_o[CY_BIT]  = as_cy;
        psw_o[AC_BIT]  = as_ac;
        psw_o[OV_BIT]  = as_ov;
      end
      OP_DA: begin
        acc_o          = da_res;
        psw_o[CY_BIT]  = da_cy;
      end
      OP_MUL: begin
        acc_o          = prod_lo;
        breg_o         = prod_hi;
        psw_o[CY_BIT]  = 1'b0;
        psw_o[OV_BIT]  = prod_wide;
      end
      OP_DIV: begin
        acc_o          = quot;
        breg_o         = rem;
        psw_o[CY_BIT]  = 1'b0;
        psw_o[OV_BIT]  = div_zero;
      end
      default: psw_o[CY_BIT] = bit_cy;
    endcase
    psw_o[P_BIT] = odd_parity(acc_o);
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = W
) (
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] breg_i,
  input logic [7:0]        psw_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] breg_o,
  input logic [7:0]        psw_o,
  input logic              div_zero,
  input logic              da_hi_step
);
  logic known;
  assign known = !$isunknown({op_i, acc_i, breg_i, psw_i, acc_o, breg_o, psw_o});

  always_comb begin
    if (known) begin
      AST_PARITY_TRACKS_ACC: assert (psw_o[P_BIT] == ($countones(acc_o) % 2 == 1)); // R3
      AST_SPARE_BITS_PASS: assert ({psw_o[5:3], psw_o[1]} == {psw_i[5:3], psw_i[1]}); // R10
      if (op_i == OP_MUL) begin
        AST_MUL_SPLIT: assert ({breg_o, acc_o} == acc_i * breg_i); // R5
        AST_MUL_CY_CLEAR: assert (!psw_o[CY_BIT]); // R5
      end
      if (op_i == OP_DIV) begin
        AST_DIV_CY_CLEAR: assert (!psw_o[CY_BIT]); // R6
        AST_DIV_ZERO_OV: assert (psw_o[OV_BIT] == div_zero); // R6
        if (!div_zero) begin
          AST_DIV_IDENTITY: assert ((acc_o * breg_i + breg_o == acc_i) && (breg_o < breg_i)); // R6
        end
      end
      if (op_i == OP_DA) begin
        AST_DA_CY_STICKY: assert (!psw_i[CY_BIT] || psw_o[CY_BIT]); // R4
        AST_DA_HI_STEP_ON_CY: assert (!psw_i[CY_BIT] || da_hi_step); // R4
      end
      if (op_i != OP_MUL && op_i != OP_DIV) begin
        AST_B_UNTOUCHED: assert (breg_o == breg_i); // R10
      end
    end
  end
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i(op_i), .acc_i(acc_i), .breg_i(breg_i), .psw_i(psw_i),
  .acc_o(acc_o), .breg_o(breg_o), .psw_o(psw_o),
  .div_zero(div_zero), .da_hi_step(da_hi_step));

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] op;
  logic [7:0] acc, opnd, breg, psw;
  logic [7:0] acc_o, breg_o, psw_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  acc_alu u_dut (.op_i(op), .acc_i(acc), .opnd_i(opnd), .breg_i(breg), .psw_i(psw),
                 .acc_o(acc_o), .breg_o(breg_o), .psw_o(psw_o));

  task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] d,
                       input logic [7:0] b, input logic [7:0] p);
    @(posedge clk);
    #1;
    op = o; acc = a; opnd = d; breg = b; psw = p;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  function automatic logic par(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) if ((v >> i) % 2 == 1) n++;
    return (n % 2) == 1;
  endfunction

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic t_idle;
    apply(4'd15, 8'h5A, 8'h00, 8'h33, 8'h00);
    chk("R9 pass A", acc_o, 8'h5A);
    chk("R10 pass B", breg_o, 8'h33);
    chk("R3 pass psw", psw_o, 8'h00);
  endtask

  task automatic t_add_examples;
    apply(4'd0, 8'hF5, 8'h0B, 8'h00, 8'h00);
    chk("R1 add A", acc_o, 8'h00);
    chk("R1 add psw", psw_o, 8'hC0);
    apply(4'd0, 8'h63, 8'h23, 8'h00, 8'h00);
    chk("R1 ov A", acc_o, 8'h86);
    chk("R1 ov psw", psw_o, 8'h05);
    apply(4'd1, 8'hE7, 8'h00, 8'h00, 8'h80);
    chk("R1 addc", acc_o, 8'hE8);
  endtask

  task automatic t_subb;
    apply(4'd2, 8'h4C, 8'h6E, 8'h00, 8'h00);
    chk("R2 subb neg A", acc_o, 8'hDE);
    chk("R2 subb neg psw", psw_o, 8'hC0);
    apply(4'd2, 8'h27, 8'h12, 8'h00, 8'h80);
    chk("R2 subb borrow-in A", acc_o, 8'h14);
    chk("R2 subb borrow-in psw", psw_o, 8'h00);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 64; i++) begin
      int a = (i * 37 + 5) % 256;
      int d = (i * 91 + 13) % 256;
      int c = i % 2;
      int s, ss, lo;
      logic [7:0] ep;
      logic sub = (i % 4) >= 2;
      if (!sub) begin
        s  = a + d + c;
        ss = sgn(a) + sgn(d) + c;
        lo = (a % 16) + (d % 16) + c;
        ep = {s > 255, lo > 15, 3'b000, (ss > 127 || ss < -128), 1'b0, par(s % 256)};
        apply(4'd1, 8'(a), 8'(d), 8'h00, {c[0], 7'h00});
        chk("R1 sweep A", acc_o, 8'(s % 256));
        chk("R1 sweep psw", psw_o, ep);
      end else begin
        s  = a - d - c;
        ss = sgn(a) - sgn(d) - c;
        ep = {s < 0, (a % 16) < (d % 16 + c), 3'b000, (ss > 127 || ss < -128), 1'b0,
              par((s + 256) % 256)};
        apply(4'd2, 8'(a), 8'(d), 8'h00, {c[0], 7'h00});
        chk("R2 sweep A", acc_o, 8'((s + 256) % 256));
        chk("R2 sweep psw", psw_o, ep);
      end
    end
  endtask

  task automatic t_da;
    logic [7:0] ra, rp;
    apply(4'd0, 8'h38, 8'h45, 8'h00, 8'h00);
    apply(4'd3, acc_o, 8'h00, 8'h00, psw_o);
    chk("R4 da low fix", acc_o, 8'h83);
    chk("R4 da low cy", psw_o & 8'h80, 8'h00);
    apply(4'd0, 8'h99, 8'h99, 8'h00, 8'h00);
    ra = acc_o; rp = psw_o;
    apply(4'd3, ra, 8'h00, 8'h00, rp);
    chk("R4 da sticky A", acc_o, 8'h98);
    chk("R4 da sticky cy", psw_o & 8'h80, 8'h80);
    apply(4'd3, 8'h9A, 8'h00, 8'h00, 8'h00);
    chk("R4 da carry out A", acc_o, 8'h00);
    chk("R4 da carry out psw", psw_o, 8'h80);
  endtask

  task automatic t_muldiv;
    apply(4'd4, 8'h25, 8'h00, 8'h65, 8'h80);
    chk("R5 mul A", acc_o, 8'h99);
    chk("R5 mul B", breg_o, 8'h0E);
    chk("R5 mul psw", psw_o, 8'h04);
    apply(4'd4, 8'h0F, 8'h00, 8'h0F, 8'h84);
    chk("R5 mul narrow psw", psw_o, 8'h00);
    apply(4'd5, 8'd95, 8'h00, 8'd10, 8'h84);
    chk("R6 div A", acc_o, 8'd9);
    chk("R6 div B", breg_o, 8'd5);
    chk("R6 div psw", psw_o, 8'h00);
    apply(4'd5, 8'h37, 8'h00, 8'h00, 8'h80);
    chk("R6 div0 psw", psw_o & 8'h84, 8'h04);
    chk("R6 div0 A", acc_o, 8'h37);
  endtask

  task automatic t_rot_swap;
    apply(4'd6, 8'h97, 8'h00, 8'h00, 8'h00);
    chk("R7 rl", acc_o, 8'h2F);
    apply(4'd8, 8'h97, 8'h00, 8'h00, 8'h00);
    chk("R7 rr", acc_o, 8'hCB);
    apply(4'd7, 8'h97, 8'h00, 8'h00, 8'h00);
    chk("R7 rlc A", acc_o, 8'h2E);
    chk("R7 rlc psw", psw_o, 8'h80);
    apply(4'd9, 8'h41, 8'h00, 8'h00, 8'h80);
    chk("R7 rrc A", acc_o, 8'hA0);
    chk("R7 rrc psw", psw_o, 8'h80);
    apply(4'd10, 8'h97, 8'h00, 8'h00, 8'h00);
    chk("R8 swap", acc_o, 8'h79);
  endtask

  task automatic t_logic_keep;
    apply(4'd11, 8'h97, 8'h0F, 8'h5C, 8'h7E);
    chk("R9 and", acc_o, 8'h07);
    chk("R10 and psw keep", psw_o, 8'h7F);
    chk("R10 and B keep", breg_o, 8'h5C);
    apply(4'd12, 8'h97, 8'h40, 8'h00, 8'h00);
    chk("R9 or", acc_o, 8'hD7);
    apply(4'd13, 8'h97, 8'hFF, 8'h00, 8'h00);
    chk("R9 xor", acc_o, 8'h68);
    apply(4'd14, 8'h97, 8'h00, 8'h00, 8'hC4);
    chk("R9 cpl", acc_o, 8'h68);
    chk("R10 cpl psw keep", psw_o, 8'hC5);
    apply(4'd3, 8'h12, 8'h00, 8'h21, 8'h3A);
    chk("R10 da keeps spare", psw_o, 8'h3A);
  endtask

  initial begin
    op = 4'd15; acc = '0; opnd = '0; breg = '0; psw = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_add_examples();
    t_subb();
    t_sweep();
    t_da();
    t_muldiv();
    t_rot_swap();
    t_logic_keep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule